// File: doc/BRIEF.md
# General-Purpose Pin Bank with Boot Strap Capture

This block controls a bank of general-purpose pins through a small register port. Software selects each pin's drive direction, updates output levels through a bit mask, and reads the synchronized pin levels. When reset releases, the block records the levels then present on the pins in a read-only strap register. Software reads this register to learn how the board is configured.

A contiguous group of pins can raise an interrupt when their level changes. Each pin has its own enable bit and its own sticky status bit, and software clears a status bit by writing one to it. The `dedicated_i` vector marks pins that another function has claimed. Software cannot change the direction or output value of those pins, they are never driven, and they read back as zero.

The block also produces a peripheral enable output for on-board devices. It goes low on reset and whenever a power-down request is present. It goes high only when software writes to set it.

Top module: `gpio_bank`

## Requirements
- R1: While reset is asserted and right after it, `gpio_oe_o`, `gpio_o`, the direction, output, interrupt-enable and interrupt-status registers, `irq_o` and `periph_en_o` are all zero.
- R2: The strap register (address 3) holds the value of `gpio_i` sampled at the first clock edge after `rst_ni` rises. It does not change until the next reset, and writes to it have no effect.
- R3: The direction register (address 0, 1 = output) is written as `dir = (dir & ~m) | (wdata & m)`, where `m = reg_wmask_i & ~dedicated_i`. It reads back at address 0, and `gpio_oe_o = dir & ~dedicated_i`.
- R4: The output register (address 1) uses the same masked write as R3 and drives `gpio_o`. It reads back at address 1.
- R5: Address 2 returns `gpio_i` after a two-flop synchronizer, ANDed with `~dedicated_i`. A pin change is visible by the third clock edge after it occurs.
- R6: A pin with its `dedicated_i` bit set is left unchanged by writes to direction and output, has `gpio_oe_o` low even if its direction bit is 1, and reads 0 at address 2.
- R7: The interrupt-enable register (address 4) occupies bits [NUM_IRQ-1:0] and is written with `reg_wmask_i`. It covers pins IRQ_BASE to IRQ_BASE+NUM_IRQ-1 (default pins 0 to 3). Its upper bits read 0.
- R8: A level change on an enabled interrupt pin sets its status bit (address 5) within four clock edges. A change on a disabled pin sets nothing. `irq_o` is the OR of all status bits.
- R9: Writing 1 to a status bit at address 5 clears it, and writing 0 leaves it unchanged.
- R10: `periph_en_o` is low while `pwr_down_i` is high and stays low after the request ends. A write of 1 to bit 0 of address 6 sets it and a write of 0 clears it. A set written while `pwr_down_i` is high has no effect. Address 6 reads back the output in bit 0.
- R11: Address 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | NUM_PINS | Write data |
| reg_wmask_i | input | NUM_PINS | Per-bit write mask for direction, output and interrupt enable |
| reg_rdata_o | output | NUM_PINS | Combinational read data for reg_addr_i |
| dedicated_i | input | NUM_PINS | Pins claimed by another function |
| pwr_down_i | input | 1 | Power-down request |
| gpio_i | input | NUM_PINS | Pin levels |
| gpio_o | output | NUM_PINS | Output levels |
| gpio_oe_o | output | NUM_PINS | Output enables, 1 = driven |
| irq_o | output | 1 | Interrupt request |
| periph_en_o | output | 1 | Peripheral enable, low = held in reset |

## Verification
Random writes use random masks over random old contents, so a bench model applies each bit only where the mask is set, and any leakage through an unmasked bit shows up. Random changes to the dedicated vector separate the effective mask from the raw one and also test output-enable gating. Pin toggles are applied with interrupt enables both set and cleared, which separates a correct edge-to-status path from a constant or ungated one. Directed cases cover the following:
- two resets with different pin levels, which shows whether the strap value tracks the pins;
- a set of the peripheral enable during power-down;
- a clear of status bits, to confirm write-one-to-clear.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR      = 3'd0,
    REG_OUT      = 3'd1,
    REG_IN       = 3'd2,
    REG_STRAP    = 3'd3,
    REG_IRQ_EN   = 3'd4,
    REG_IRQ_STAT = 3'd5,
    REG_PERIPH   = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d_i;
        else stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_strap.sv
module gpio_bank_strap #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pins_i,
  output logic [WIDTH-1:0] strap_o
);
  logic armed_q;

  // raw pins sampled once, on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      strap_o <= '0;
    end else if (!armed_q) begin
      armed_q <= 1'b1;
      strap_o <= pins_i;
    end
  end
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] pin_sync_i,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic [NUM_IRQ-1:0] clr_i,
  output logic [NUM_IRQ-1:0] stat_o,
  output logic               irq_o
);
  logic [NUM_IRQ-1:0] prev_q;
  logic [NUM_IRQ-1:0] change;

  assign change = (pin_sync_i ^ prev_q) & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      stat_o <= '0;
    end else begin
      prev_q <= pin_sync_i;
      stat_o <= (stat_o & ~clr_i) | change;  // new event wins over clear
    end
  end

  assign irq_o = |stat_o;
endmodule

// File: rtl/gpio_bank_periph_en.sv
module gpio_bank_periph_en (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_down_i,
  input  logic wr_i,
  input  logic wval_i,
  output logic en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= 1'b0;
    else if (pwr_down_i) en_o <= 1'b0;
    else if (wr_i) en_o <= wval_i;
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int NUM_IRQ  = 4,
  parameter int IRQ_BASE = 0,
  parameter int SYNC_STG = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [NUM_PINS-1:0] reg_wdata_i,
  input  logic [NUM_PINS-1:0] reg_wmask_i,
  output logic [NUM_PINS-1:0] reg_rdata_o,
  input  logic [NUM_PINS-1:0] dedicated_i,
  input  logic                pwr_down_i,
  input  logic [NUM_PINS-1:0] gpio_i,
  output logic [NUM_PINS-1:0] gpio_o,
  output logic [NUM_PINS-1:0] gpio_oe_o,
  output logic                irq_o,
  output logic                periph_en_o
);
  logic [NUM_PINS-1:0] dir_q, out_q, pin_sync, strap_q, sw_mask;
  logic [NUM_IRQ-1:0]  irq_en_q, irq_stat, irq_clr;
  logic                wr_dir, wr_out, wr_en, wr_stat, wr_per;

  assign wr_dir  = reg_we_i && (reg_addr_i == REG_DIR);
  assign wr_out  = reg_we_i && (reg_addr_i == REG_OUT);
  assign wr_en   = reg_we_i && (reg_addr_i == REG_IRQ_EN);
  assign wr_stat = reg_we_i && (reg_addr_i == REG_IRQ_STAT);
  assign wr_per  = reg_we_i && (reg_addr_i == REG_PERIPH);
  assign sw_mask = reg_wmask_i & ~dedicated_i;
  assign irq_clr = wr_stat ? reg_wdata_i[NUM_IRQ-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q    <= '0;
      out_q    <= '0;
      irq_en_q <= '0;
    end else begin
      if (wr_dir) dir_q <= (dir_q & ~sw_mask) | (reg_wdata_i & sw_mask);
      if (wr_out) out_q <= (out_q & ~sw_mask) | (reg_wdata_i & sw_mask);
      if (wr_en)
        irq_en_q <= (irq_en_q & ~reg_wmask_i[NUM_IRQ-1:0])
                  | (reg_wdata_i[NUM_IRQ-1:0] & reg_wmask_i[NUM_IRQ-1:0]);
    end
  end

  gpio_bank_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STG)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(gpio_i), .q_o(pin_sync)
  );

  gpio_bank_strap #(.WIDTH(NUM_PINS)) u_strap (
    .clk_i(clk_i), .rst_ni(rst_ni), .pins_i(gpio_i), .strap_o(strap_q)
  );

  gpio_bank_irq #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pin_sync_i(pin_sync[IRQ_BASE +: NUM_IRQ]),
    .en_i(irq_en_q), .clr_i(irq_clr),
    .stat_o(irq_stat), .irq_o(irq_o)
  );

  gpio_bank_periph_en u_per (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_down_i(pwr_down_i),
    .wr_i(wr_per), .wval_i(reg_wdata_i[0]), .en_o(periph_en_o)
  );

  assign gpio_o    = out_q;
  assign gpio_oe_o = dir_q & ~dedicated_i;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_DIR:      reg_rdata_o = dir_q;
      REG_OUT:      reg_rdata_o = out_q;
      REG_IN:       reg_rdata_o = pin_sync & ~dedicated_i;
      REG_STRAP:    reg_rdata_o = strap_q;
      REG_IRQ_EN:   reg_rdata_o[NUM_IRQ-1:0] = irq_en_q;
      REG_IRQ_STAT: reg_rdata_o[NUM_IRQ-1:0] = irq_stat;
      REG_PERIPH:   reg_rdata_o[0] = periph_en_o;
      default:      reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_PINS = 16,
  parameter int NUM_IRQ  = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                reg_we_i,
  input logic [2:0]          reg_addr_i,
  input logic [NUM_PINS-1:0] reg_wdata_i,
  input logic [NUM_PINS-1:0] dedicated_i,
  input logic                pwr_down_i,
  input logic [NUM_PINS-1:0] gpio_o,
  input logic [NUM_PINS-1:0] gpio_oe_o,
  input logic                periph_en_o,
  input logic [NUM_PINS-1:0] strap_q,
  input logic [NUM_IRQ-1:0]  irq_stat,
  input logic [NUM_IRQ-1:0]  irq_en_q
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 2'd2) cyc_q <= cyc_q + 2'd1;
  end

  a_r2_strap_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2) |-> $stable(strap_q));

  a_r3_oe_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> ($stable(dedicated_i) -> $stable(gpio_oe_o)));

  a_r4_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> $stable(gpio_o));

  a_r6_no_drive_dedicated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpio_oe_o & dedicated_i) == '0);

  a_r8_stat_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0) |-> ((irq_stat & ~$past(irq_stat) & ~$past(irq_en_q)) == '0));

  a_r10_pwrdn_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_i |=> !periph_en_o);

  a_r10_rise_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(periph_en_o) |-> $past(reg_we_i && reg_addr_i == 3'd6 && reg_wdata_i[0]));
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS), .NUM_IRQ(NUM_IRQ)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .dedicated_i(dedicated_i), .pwr_down_i(pwr_down_i),
  .gpio_o(gpio_o), .gpio_oe_o(gpio_oe_o), .periph_en_o(periph_en_o),
  .strap_q(strap_q), .irq_stat(irq_stat), .irq_en_q(irq_en_q)
);

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
  localparam int N  = 16;
  localparam int NI = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         reg_we_i = 1'b0;
  logic [2:0]   reg_addr_i = '0;
  logic [N-1:0] reg_wdata_i = '0, reg_wmask_i = '0, reg_rdata_o;
  logic [N-1:0] dedicated_i = '0, gpio_i = '0, gpio_o, gpio_oe_o;
  logic         pwr_down_i = 1'b0, irq_o, periph_en_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [N-1:0]  m_dir, m_out, m_strap;
  logic [NI-1:0] m_en, m_stat;
  logic          m_per;

  always #2.5 clk_i = ~clk_i;

  gpio_bank dut_i (.*);

  function automatic logic [N-1:0] exp_read(input int a);
    logic [N-1:0] v = '0;
    case (a)
      0: v = m_dir;
      1: v = m_out;
      2: v = gpio_i & ~dedicated_i;
      3: v = m_strap;
      4: v[NI-1:0] = m_en;
      5: v[NI-1:0] = m_stat;
      6: v[0] = m_per;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic string req_of(input int a);
    case (a)
      0: return "R3"; 1: return "R4"; 2: return "R5"; 3: return "R2";
      4: return "R7"; 5: return "R8"; 6: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic chk(input string r, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check_all();
    for (int a = 0; a < 8; a++) begin
      reg_addr_i = 3'(a);
      #0.5;
      chk(req_of(a), reg_rdata_o, exp_read(a));
    end
    chk("R4", gpio_o, m_out);
    chk("R6", gpio_oe_o, m_dir & ~dedicated_i);
    chk("R8", N'(irq_o), N'(|m_stat));
    chk("R10", N'(periph_en_o), N'(m_per));
  endtask

  task automatic wr(input int a, input logic [N-1:0] d, input logic [N-1:0] m);
    logic [N-1:0] em = m & ~dedicated_i;
    reg_we_i = 1'b1; reg_addr_i = 3'(a); reg_wdata_i = d; reg_wmask_i = m;
    tick(1);
    reg_we_i = 1'b0;
    case (a)
      0: m_dir = (m_dir & ~em) | (d & em);
      1: m_out = (m_out & ~em) | (d & em);
      4: m_en  = (m_en & ~m[NI-1:0]) | (d[NI-1:0] & m[NI-1:0]);
      5: m_stat = m_stat & ~d[NI-1:0];
      6: if (!pwr_down_i) m_per = d[0];
      default: ;
    endcase
  endtask

  task automatic set_pins(input logic [N-1:0] p);
    m_stat = m_stat | ((gpio_i[NI-1:0] ^ p[NI-1:0]) & m_en);
    gpio_i = p;
    tick(4);
  endtask

  task automatic do_reset(input logic [N-1:0] p);
    rst_ni = 1'b0; gpio_i = p; pwr_down_i = 1'b0; dedicated_i = '0;
    tick(1);
    chk("R1", gpio_oe_o, '0);
    chk("R1", gpio_o, '0);
    chk("R1", N'({irq_o, periph_en_o}), '0);
    tick(1);
    rst_ni = 1'b1;
    tick(4);
    m_dir = '0; m_out = '0; m_en = '0; m_stat = '0; m_per = 1'b0; m_strap = p;
    check_all();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    tick(1);
    do_reset(16'hA5C3);
    // R2 strap unaffected by pin changes and writes
    set_pins(16'h0F0F);
    wr(3, '1, '1);
    check_all();
    // R3 R4 R6 masked writes with dedicated pins
    dedicated_i = 16'h00F0;
    wr(0, 16'hFFFF, 16'h00FF);
    wr(1, 16'h1234, 16'hF0F0);
    check_all();
    // R7 R8 enabled vs disabled edges, R9 clear
    wr(4, 16'hFFF5, 16'hFFFF);
    set_pins(gpio_i ^ 16'h000F);
    check_all();
    wr(5, 16'h0001, '0);
    check_all();
    wr(5, 16'hFFFF, '0);
    check_all();
    // R10 set, power-down, set during power-down, release
    wr(6, 16'h1, '0);
    check_all();
    pwr_down_i = 1'b1; m_per = 1'b0;
    tick(2);
    wr(6, 16'h1, '0);
    check_all();
    pwr_down_i = 1'b0;
    tick(2);
    check_all();
    wr(6, 16'h1, '0);
    check_all();
    // random mix
    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(0, 9);
      if (k < 6) begin
        int a = $urandom_range(0, 7);
        wr(a, N'($urandom), N'($urandom));
      end else if (k < 8) begin
        set_pins(N'($urandom));
      end else if (k == 8) begin
        dedicated_i = N'($urandom) & N'($urandom);
        tick(1);
      end else begin
        pwr_down_i = 1'b1; m_per = 1'b0;
        tick($urandom_range(1, 3));
        pwr_down_i = 1'b0;
        tick(1);
      end
      check_all();
    end
    // R1 R2 second reset with other levels
    do_reset(16'h3C5A);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule